// File: doc/BRIEF.md
# Calorimeter Front-End Event Record Builder

This block collects what a 72-channel calorimeter front-end produces for one trigger and turns it into a single fixed-length record. When the trigger pulse arrives it captures the bunch-crossing number, the 72 ADC conversion results with their per-channel gain-range bits, and the static chip identifier. It packs them into one record word and writes that word into a small on-chip store that holds a few events per acquisition window.

Readout runs over a serial line shared by every chip on a detector slab. The chips pass a token down the chain. A chip that receives the token sends all of its stored records, one bit per clock, in the order the triggers came in. It then hands the token on with a one-cycle pulse. A chip with nothing stored hands the token on at once. Triggers beyond the store depth are dropped and recorded in a sticky overflow flag.

Top module: `evt_builder`

## Requirements
- R1: A record is CHIP_W + BCID_W + NUM_CH + NUM_CH*ADC_W bits long, which is 968 at the defaults. On the wire the chip ID comes first, then the bunch-crossing ID, then the gain bits from channel 0 upward, then the ADC words from channel 0 upward. Every multi-bit field is sent MSB first.
- R2: A `trig` pulse captures the current `bcid_in`, `gain_in`, `adc_in` and `chip_id` into the next free slot. Channel i sits at `adc_in[i*ADC_W +: ADC_W]` and `gain_in[i]`.
- R3: At most DEPTH events (5 by default) are stored. A trigger that arrives while the store is full is dropped. Such a trigger sets `overflow` in the next cycle, and `overflow` then stays high.
- R4: `acq_start` empties the store and clears `overflow`. A `trig` in the same cycle as `acq_start` is discarded.
- R5: When `token_in` is sampled with N > 0 events stored, the first record bit appears on `sdata` in the next cycle. One bit follows per cycle, events go out in trigger order, and `sdata_en` is high for exactly N*record-length cycles.
- R6: `sdata` is 0 whenever `sdata_en` is low. The chip drives data only while it holds the token.
- R7: `token_out` is a one-cycle pulse in the cycle after the last record bit. At that point the stored events are discarded.
- R8: With no events stored, `token_out` pulses in the cycle after `token_in` is sampled, and `sdata_en` stays low.
- R9: During readout, `trig`, `acq_start` and `token_in` are ignored. No event is stored, `overflow` keeps its value, and the record stream is not disturbed.
- R10: After reset, `sdata_en`, `token_out` and `overflow` are low and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_start | input | 1 | Start of acquisition window: empties store, clears overflow |
| trig | input | 1 | Trigger pulse: capture one event |
| bcid_in | input | BCID_W | Bunch-crossing number at trigger |
| adc_in | input | NUM_CH*ADC_W | ADC results, channel i at [i*ADC_W +: ADC_W] |
| gain_in | input | NUM_CH | Gain-range bit per channel |
| chip_id | input | CHIP_W | Static chip identifier |
| token_in | input | 1 | Token arriving from the previous chip |
| sdata | output | 1 | Serial record data |
| sdata_en | output | 1 | High while this chip drives the shared line |
| token_out | output | 1 | Token pulse to the next chip |
| overflow | output | 1 | Sticky: a trigger was dropped this window |

## Verification
`overflow` rises one cycle after the trigger that found the store full. The first record bit is due one cycle after `token_in` is sampled, and each following bit one cycle later. `token_out` is due exactly one cycle after the last bit, or one cycle after `token_in` when the store is empty. The bench drives every input on the falling edge and samples on the falling edge, so each comparison lands half a cycle after the register update that produced it. It counts bits from the token cycle to decide which record position it expects. Fill levels from zero to full, overflow, and injections during readout are swept on a reduced configuration. Every expected bit is computed by field arithmetic.

// File: rtl/eb_pkg.sv
package eb_pkg;
  typedef enum logic {RO_IDLE, RO_SEND} ro_state_t;

  function automatic int rec_width(int nch, int aw, int bw, int cw);
    return cw + bw + nch + nch * aw;
  endfunction
endpackage

// File: rtl/eb_packer.sv
module eb_packer #(
  parameter int NUM_CH = 72,
  parameter int ADC_W  = 12,
  parameter int BCID_W = 24,
  parameter int CHIP_W = 8,
  parameter int RW     = eb_pkg::rec_width(NUM_CH, ADC_W, BCID_W, CHIP_W)
) (
  input  logic [CHIP_W-1:0]       chip_id,
  input  logic [BCID_W-1:0]       bcid,
  input  logic [NUM_CH-1:0]       gain,
  input  logic [NUM_CH*ADC_W-1:0] adc,
  output logic [RW-1:0]           rec
);
  logic [NUM_CH-1:0]       gain_ord;
  logic [NUM_CH*ADC_W-1:0] adc_ord;

  // channel 0 lands in the most significant slot so it leaves first
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ord
    assign gain_ord[NUM_CH-1-i]               = gain[i];
    assign adc_ord[(NUM_CH-1-i)*ADC_W +: ADC_W] = adc[i*ADC_W +: ADC_W];
  end

  assign rec = {chip_id, bcid, gain_ord, adc_ord};
endmodule

// File: rtl/eb_store.sv
module eb_store #(
  parameter int DEPTH = 5,
  parameter int RW    = 968,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic            clr_acq,
  input  logic            clr_read,
  input  logic [RW-1:0]   rec_in,
  input  logic [CNTW-1:0] rd_idx,
  output logic [RW-1:0]   rd_rec,
  output logic [CNTW-1:0] count,
  output logic            overflow,
  output logic            wr_fire,
  output logic            ovf_fire
);
  logic [RW-1:0] mem [DEPTH];
  logic          full;

  assign full     = (count == CNTW'(DEPTH));
  assign wr_fire  = wr_req && !full;
  assign ovf_fire = wr_req && full;
  assign rd_rec   = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[count] <= rec_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (clr_acq) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (clr_read)     count <= '0;
      else if (wr_fire) count <= count + 1'b1;
      if (ovf_fire)     overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/eb_serializer.sv
module eb_serializer #(
  parameter int DEPTH = 5,
  parameter int RW    = 968,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            token_in,
  input  logic [CNTW-1:0] ev_count,
  input  logic [RW-1:0]   rd_rec,
  output logic [CNTW-1:0] rd_idx,
  output logic            busy,
  output logic            sdata,
  output logic            sdata_en,
  output logic            token_out,
  output logic            ro_done
);
  import eb_pkg::*;
  localparam int BIX = $clog2(RW);

  ro_state_t       state;
  logic [BIX-1:0]  bit_idx;
  logic [CNTW-1:0] ev_idx;
  logic [BIX-1:0]  sel;
  logic            last_bit;

  assign busy     = (state == RO_SEND);
  assign last_bit = (bit_idx == BIX'(RW - 1));
  assign ro_done  = busy && last_bit && (ev_idx == CNTW'(ev_count - 1'b1));
  assign sel      = BIX'(RW - 1) - bit_idx;
  assign sdata    = busy ? rd_rec[sel] : 1'b0;
  assign sdata_en = busy;
  assign rd_idx   = ev_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RO_IDLE;
      bit_idx   <= '0;
      ev_idx    <= '0;
      token_out <= 1'b0;
    end else begin
      token_out <= 1'b0;
      case (state)
        RO_IDLE: if (token_in) begin
          if (ev_count == '0) token_out <= 1'b1;
          else begin
            state   <= RO_SEND;
            bit_idx <= '0;
            ev_idx  <= '0;
          end
        end
        RO_SEND: begin
          if (last_bit) begin
            bit_idx <= '0;
            if (ro_done) begin
              state     <= RO_IDLE;
              token_out <= 1'b1;
            end else ev_idx <= ev_idx + 1'b1;
          end else bit_idx <= bit_idx + 1'b1;
        end
        default: state <= RO_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_builder.sv
module evt_builder #(
  parameter int NUM_CH = 72,
  parameter int ADC_W  = 12,
  parameter int BCID_W = 24,
  parameter int CHIP_W = 8,
  parameter int DEPTH  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acq_start,
  input  logic                    trig,
  input  logic [BCID_W-1:0]       bcid_in,
  input  logic [NUM_CH*ADC_W-1:0] adc_in,
  input  logic [NUM_CH-1:0]       gain_in,
  input  logic [CHIP_W-1:0]       chip_id,
  input  logic                    token_in,
  output logic                    sdata,
  output logic                    sdata_en,
  output logic                    token_out,
  output logic                    overflow
);
  localparam int RW   = eb_pkg::rec_width(NUM_CH, ADC_W, BCID_W, CHIP_W);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [RW-1:0]   rec_new, rd_rec;
  logic [CNTW-1:0] ev_count, rd_idx;
  logic            busy, wr_req, clr_acq, wr_fire, ovf_fire, ro_done;

  assign clr_acq = acq_start && !busy;
  assign wr_req  = trig && !busy && !acq_start;

  eb_packer #(.NUM_CH(NUM_CH), .ADC_W(ADC_W), .BCID_W(BCID_W), .CHIP_W(CHIP_W), .RW(RW))
    pack_i (.chip_id(chip_id), .bcid(bcid_in), .gain(gain_in), .adc(adc_in), .rec(rec_new));

  eb_store #(.DEPTH(DEPTH), .RW(RW), .CNTW(CNTW)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .clr_acq(clr_acq), .clr_read(ro_done),
    .rec_in(rec_new), .rd_idx(rd_idx), .rd_rec(rd_rec), .count(ev_count),
    .overflow(overflow), .wr_fire(wr_fire), .ovf_fire(ovf_fire));

  eb_serializer #(.DEPTH(DEPTH), .RW(RW), .CNTW(CNTW)) ser_i (
    .clk(clk), .rst_n(rst_n), .token_in(token_in), .ev_count(ev_count), .rd_rec(rd_rec),
    .rd_idx(rd_idx), .busy(busy), .sdata(sdata), .sdata_en(sdata_en),
    .token_out(token_out), .ro_done(ro_done));
endmodule

// File: rtl/eb_checks.sv
module eb_checks #(
  parameter int DEPTH = 5,
  parameter int CNTW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acq_start,
  input logic            token_in,
  input logic            busy,
  input logic [CNTW-1:0] ev_count,
  input logic            sdata,
  input logic            sdata_en,
  input logic            token_out,
  input logic            overflow,
  input logic            wr_fire,
  input logic            ovf_fire
);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_count <= CNTW'(DEPTH));
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_fire |=> overflow);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !(acq_start && !busy) |=> overflow);
  p_send_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    token_in && !busy && ev_count != '0 |=> sdata_en);
  p_quiet_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_en |-> !sdata);
  p_token_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |=> !token_out);
  p_token_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |-> ev_count == '0 && !sdata_en);
  p_empty_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    token_in && !busy && ev_count == '0 |=> token_out && !sdata_en);
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_fire);
endmodule

bind evt_builder eb_checks #(.DEPTH(DEPTH), .CNTW(CNTW)) chk_i (
  .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .token_in(token_in), .busy(busy),
  .ev_count(ev_count), .sdata(sdata), .sdata_en(sdata_en), .token_out(token_out),
  .overflow(overflow), .wr_fire(wr_fire), .ovf_fire(ovf_fire));

// File: tb/evt_builder_tb_top.sv
module evt_builder_tb_top;
  localparam int NCH = 2, AW = 4, BW = 6, CW = 3, DEPTH = 3;
  localparam int RW  = CW + BW + NCH + NCH * AW;
  localparam logic [CW-1:0] CHIP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acq_start = 0, trig = 0, token_in = 0;
  logic [BW-1:0] bcid_in = '0;
  logic [NCH*AW-1:0] adc_in = '0;
  logic [NCH-1:0] gain_in = '0;
  logic sdata, sdata_en, token_out, overflow;

  int total = 0, failed = 0, serial = 0, nstored = 0;
  int slot_serial [DEPTH];

  always #2.5 clk = ~clk;

  evt_builder #(.NUM_CH(NCH), .ADC_W(AW), .BCID_W(BW), .CHIP_W(CW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .trig(trig), .bcid_in(bcid_in),
    .adc_in(adc_in), .gain_in(gain_in), .chip_id(CHIP), .token_in(token_in),
    .sdata(sdata), .sdata_en(sdata_en), .token_out(token_out), .overflow(overflow));

  function automatic int bcid_of(int s); return (s * 11 + 7) % 64; endfunction
  function automatic int adc_of(int s, int ch); return (s * 5 + ch * 3 + 1) % 16; endfunction
  function automatic int gain_of(int s, int ch); return (s + ch) % 2; endfunction

  function automatic int exp_bit(int s, int pos);
    int p = pos;
    if (p < CW) return (CHIP >> (CW - 1 - p)) & 1;
    p -= CW;
    if (p < BW) return (bcid_of(s) >> (BW - 1 - p)) & 1;
    p -= BW;
    if (p < NCH) return gain_of(s, p);
    p -= NCH;
    return (adc_of(s, p / AW) >> (AW - 1 - p % AW)) & 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic pulse_acq();
    @(negedge clk) acq_start = 1;
    @(negedge clk) acq_start = 0;
    nstored = 0;
  endtask

  // R2: one trigger with serial-derived data; bench tracks which slot it should land in
  task automatic fire();
    @(negedge clk);
    bcid_in = BW'(bcid_of(serial));
    for (int ch = 0; ch < NCH; ch++) begin
      adc_in[ch*AW +: AW] = AW'(adc_of(serial, ch));
      gain_in[ch] = 1'(gain_of(serial, ch));
    end
    trig = 1;
    if (nstored < DEPTH) begin slot_serial[nstored] = serial; nstored++; end
    serial++;
    @(negedge clk) trig = 0;
  endtask

  // readout of n events; inject>=0 pulses trig/acq_start/token_in at that bit (R9)
  task automatic readout(int n, int inject);
    int errs = 0, en_errs = 0, act0 = 0, exp0 = 0;
    @(negedge clk) token_in = 1;
    @(negedge clk) token_in = 0;
    for (int e = 0; e < n; e++) begin
      errs = 0;
      for (int b = 0; b < RW; b++) begin
        int idx = e * RW + b;
        if (!sdata_en) en_errs++;
        if (int'(sdata) != exp_bit(slot_serial[e], b)) begin
          if (errs == 0) begin act0 = int'(sdata); exp0 = exp_bit(slot_serial[e], b); end
          errs++;
        end
        if (idx == inject) begin trig = 1; acq_start = 1; token_in = 1; end
        @(negedge clk);
        trig = 0; acq_start = 0; token_in = 0;
      end
      chk(errs == 0, "R1/R5 record bits", act0, exp0);
    end
    chk(en_errs == 0, "R5 sdata_en during record", en_errs, 0);
    chk(token_out == 1'b1, n == 0 ? "R8 token passed at once" : "R7 token after last bit",
        int'(token_out), 1);
    chk(sdata_en == 1'b0 && sdata == 1'b0, "R6 line quiet after token", int'(sdata_en), 0);
    @(negedge clk);
    chk(token_out == 1'b0, "R7 token pulse one cycle", int'(token_out), 0);
    nstored = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk(!sdata_en && !token_out && !overflow, "R10 reset outputs", int'(overflow), 0);
    readout(0, -1);  // R10 empty store, R8

    // R2 R5 R7: sweep every fill level over two windows
    for (int w = 0; w < 2; w++)
      for (int n = 0; n <= DEPTH; n++) begin
        pulse_acq();
        for (int k = 0; k < n; k++) fire();
        chk(overflow == 1'b0, "R3 no overflow within depth", int'(overflow), 0);
        readout(n, -1);
      end

    // R3: overflow on the trigger after the store fills
    pulse_acq();
    for (int k = 0; k < DEPTH; k++) fire();
    chk(overflow == 1'b0, "R3 full store no overflow yet", int'(overflow), 0);
    fire();
    chk(overflow == 1'b1, "R3 extra trigger sets overflow", int'(overflow), 1);
    fire();
    // R9: injection mid-readout must not store, clear, or disturb the stream
    readout(DEPTH, 2);
    chk(overflow == 1'b1, "R3/R9 overflow sticky through readout", int'(overflow), 1);
    readout(0, -1);  // R9 trig during readout stored nothing
    pulse_acq();
    chk(overflow == 1'b0, "R4 acq_start clears overflow", int'(overflow), 0);

    // R4: acq_start empties store; simultaneous trig discarded
    fire(); fire();
    @(negedge clk) begin acq_start = 1; trig = 1; end
    @(negedge clk) begin acq_start = 0; trig = 0; end
    nstored = 0;
    readout(0, -1);

    // R2: a single event after the clear reads back correctly
    fire();
    readout(1, -1);
    summary();
  end
endmodule